// File: doc/BRIEF.md
# Two-Thread Coarse-Grained Switch Controller

This block chooses which of two hardware threads may issue on an in-order core. One thread is the foreground thread and issues. The other is the background thread and holds its state idle. The controller watches miss notifications for the foreground thread and miss completions for either thread. From these it decides when the two threads exchange roles. It drives the selected thread ID, an issue enable, a one-cycle pipeline flush request and an all-stalled flag. It also keeps, for each thread, a count of the switches taken away from it.

A miss is reported with `missValid` and is classed as long or short by `missLong`. A long miss always gives the processor to the other thread. A short miss gives it to the other thread only when that thread can run. Otherwise the foreground thread keeps the selection and stalls. After a role exchange there is a fixed penalty before the new foreground thread issues. While that penalty is running, no new decision is made. When both threads are waiting, nothing issues, and the first thread whose miss completes is selected.

Top module: `thread_switch_ctl`

## Requirements
- R1: After reset, thread 0 is foreground (`fgThread`=0), both threads are running, `issueEn`=1, `flushReq`=0, `allStalled`=0 and both switch counts are 0.
- R2: A miss is accepted only in a cycle with `issueEn`=1 and `missValid`=1. An accepted miss puts the foreground thread into waiting-long (`missLong`=1) or waiting-short (`missLong`=0).
- R3: An accepted short miss while the background thread is running, or is completing in the same cycle, exchanges the roles. In the next cycle `fgThread` shows the other thread and `flushReq`=1.
- R4: An accepted short miss while the background thread is waiting and not completing keeps `fgThread` unchanged with `flushReq`=0. `issueEn` then stays 0 until a matching completion for that thread. `issueEn` returns to 1 in the cycle after the completion.
- R5: Say a switch is decided in cycle t. Then `flushReq` is 1 in cycle t+1 only, `issueEn` is 0 in cycles t+1 and t+2, and the new foreground thread may issue from cycle t+3 (SWITCH_LAT=3).
- R6: `missValid` has no effect in cycles with `issueEn`=0, including the penalty cycles.
- R7: `retValid[i]` completes thread i's wait only when `retLong[i]` matches its class (1 = long, 0 = short) and thread i is waiting. Any other completion is ignored.
- R8: When both threads are waiting, `allStalled`=1 and `issueEn`=0. If only the background thread completes first, the roles are exchanged. If only the foreground thread completes, it resumes without a switch.
- R9: If both threads are waiting and both complete in the same cycle, the background thread becomes foreground.
- R10: An accepted long miss exchanges the roles even when the background thread is still waiting.
- R11: Each switch increments the count of the thread that was foreground when the switch was decided (`swCnt0` for thread 0, `swCnt1` for thread 1). The count is visible one cycle later and wraps at 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| missValid | input | 1 | Foreground thread reports a miss this cycle |
| missLong | input | 1 | Class of the reported miss: 1 long, 0 short |
| retValid | input | 2 | Per-thread miss completion, bit i for thread i |
| retLong | input | 2 | Class of each completion: 1 long, 0 short |
| fgThread | output | 1 | ID of the foreground thread |
| issueEn | output | 1 | Foreground thread may issue this cycle |
| flushReq | output | 1 | One-cycle pipeline flush after a switch |
| allStalled | output | 1 | Both threads are waiting on misses |
| swCnt0 | output | CNT_W | Switches taken away from thread 0 |
| swCnt1 | output | CNT_W | Switches taken away from thread 1 |

## Verification
The assertions assume that every input has a known 0/1 value at each rising edge after reset. They also assume that `missLong` and `retLong` are meaningful only alongside their valid bits. They make no assumption about when completions arrive. A completion may target a running thread, carry the wrong class, or land during a penalty. The stimulus changes all inputs only at the falling edge. It draws them from zeroes or a linear feedback shift register, so every input is defined and stable at each sampling edge. The stimulus still covers completions of the wrong class, completions to running threads, and misses offered during penalty and stall cycles.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  // per-thread status
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_WAIT_S = 2'd1,
    ST_WAIT_L = 2'd2
  } thrStat_t;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptMiss;
    logic doSwitch;
  } tswStrobe_t;

endpackage

// File: rtl/tsw_datapath.sv
module tsw_datapath
  import tsw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tswStrobe_t       strobe,
  input  logic             missLong,
  input  logic [1:0]       retValid,
  input  logic [1:0]       retLong,
  output logic             fgSel,
  output logic             fgRun,
  output logic             bgReadyNow,
  output logic             bothWaiting,
  output logic [CNT_W-1:0] swCnt0,
  output logic [CNT_W-1:0] swCnt1
);

  localparam int NUM_THR = 2;

  logic             fgQ;
  logic             bgSel;
  thrStat_t         statQ [NUM_THR];
  logic [CNT_W-1:0] cntQ  [NUM_THR];
  logic [NUM_THR-1:0] retHit;
  logic [NUM_THR-1:0] isRun;

  // completion is honoured only for a waiting thread of the same class
  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    assign isRun[g]  = (statQ[g] == ST_RUN);
    assign retHit[g] = retValid[g] && !isRun[g] &&
                       (retLong[g] == (statQ[g] == ST_WAIT_L));
  end

  assign bgSel       = ~fgQ;
  assign fgSel       = fgQ;
  assign fgRun       = isRun[fgQ];
  assign bgReadyNow  = isRun[bgSel] || retHit[bgSel];
  assign bothWaiting = !isRun[0] && !isRun[1];
  assign swCnt0      = cntQ[0];
  assign swCnt1      = cntQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fgQ <= 1'b0;
      for (int i = 0; i < NUM_THR; i++) begin
        statQ[i] <= ST_RUN;
        cntQ[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_THR; i++) begin
        if (strobe.acceptMiss && (fgQ == 1'(i)))
          statQ[i] <= missLong ? ST_WAIT_L : ST_WAIT_S;
        else if (retHit[i])
          statQ[i] <= ST_RUN;
      end
      if (strobe.doSwitch) begin
        fgQ       <= bgSel;
        cntQ[fgQ] <= cntQ[fgQ] + 1'b1;
      end
    end
  end

  // R2: an accepted miss leaves the foreground thread waiting
  p_wait_after_miss_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.acceptMiss && !fgQ) |=> (statQ[0] != ST_RUN));

  // R11: a switch away from thread 0 bumps only its count
  p_count_thr0_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doSwitch && !fgQ) |=> (cntQ[0] == $past(cntQ[0]) + 1'b1) && $stable(cntQ[1]));

  // R11: a switch away from thread 1 bumps only its count
  p_count_thr1_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doSwitch && fgQ) |=> (cntQ[1] == $past(cntQ[1]) + 1'b1) && $stable(cntQ[0]));

endmodule

// File: rtl/tsw_ctrl.sv
module tsw_ctrl
  import tsw_pkg::*;
#(
  parameter int SWITCH_LAT = 3   // cycles from decision to first issue, >= 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       missValid,
  input  logic       missLong,
  input  logic       fgRun,
  input  logic       bgReadyNow,
  output tswStrobe_t strobe,
  output logic       issueEn,
  output logic       flushReq
);

  localparam int PEN_W = $clog2(SWITCH_LAT + 1);

  typedef enum logic {C_ISSUE = 1'b0, C_PENALTY = 1'b1} ctlState_t;

  ctlState_t        stQ;
  logic [PEN_W-1:0] penQ;
  logic             flushQ;
  logic             inIssue;

  assign inIssue           = (stQ == C_ISSUE);
  assign issueEn           = inIssue && fgRun;
  assign strobe.acceptMiss = issueEn && missValid;
  // long miss always moves; short miss or a stalled foreground moves only to a runnable thread
  assign strobe.doSwitch   = inIssue &&
                             (strobe.acceptMiss ? (missLong || bgReadyNow)
                                                : (!fgRun && bgReadyNow));
  assign flushReq          = flushQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ    <= C_ISSUE;
      penQ   <= '0;
      flushQ <= 1'b0;
    end else begin
      flushQ <= strobe.doSwitch;
      if (strobe.doSwitch) begin
        stQ  <= C_PENALTY;
        penQ <= PEN_W'(SWITCH_LAT - 2);
      end else if (stQ == C_PENALTY) begin
        if (penQ == '0) stQ <= C_ISSUE;
        else            penQ <= penQ - 1'b1;
      end
    end
  end

  // R5: flush lasts exactly one cycle
  p_flush_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> !flushReq);

  // R5: nothing issues in the flush cycle
  p_flush_no_issue_r5: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> !issueEn);

  // R6: a switch decision never comes from the penalty window
  p_no_switch_in_penalty_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == C_PENALTY) |-> !strobe.doSwitch);

endmodule

// File: rtl/thread_switch_ctl.sv
module thread_switch_ctl
  import tsw_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SWITCH_LAT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             missValid,
  input  logic             missLong,
  input  logic [1:0]       retValid,
  input  logic [1:0]       retLong,
  output logic             fgThread,
  output logic             issueEn,
  output logic             flushReq,
  output logic             allStalled,
  output logic [CNT_W-1:0] swCnt0,
  output logic [CNT_W-1:0] swCnt1
);

  tswStrobe_t strobe;
  logic       fgRun;
  logic       bgReadyNow;

  tsw_ctrl #(.SWITCH_LAT(SWITCH_LAT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .missValid  (missValid),
    .missLong   (missLong),
    .fgRun      (fgRun),
    .bgReadyNow (bgReadyNow),
    .strobe     (strobe),
    .issueEn    (issueEn),
    .flushReq   (flushReq)
  );

  tsw_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .missLong    (missLong),
    .retValid    (retValid),
    .retLong     (retLong),
    .fgSel       (fgThread),
    .fgRun       (fgRun),
    .bgReadyNow  (bgReadyNow),
    .bothWaiting (allStalled),
    .swCnt0      (swCnt0),
    .swCnt1      (swCnt1)
  );

  // R8: nothing issues while both threads wait
  p_stall_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    allStalled |-> !issueEn);

  // R3: the selection only moves together with a flush
  p_fg_moves_with_flush_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fgThread) |-> flushReq);

endmodule

// File: tb/thread_switch_ctl_bench.sv
module thread_switch_ctl_bench;

  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic missValid = 1'b0, missLong = 1'b0;
  logic [1:0] retValid = '0, retLong = '0;
  logic fgThread, issueEn, flushReq, allStalled;
  logic [CNT_W-1:0] swCnt0, swCnt1;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // reference state, built from the requirements
  logic       mFg;
  int         mSt [2];   // 0 run, 1 waiting short, 2 waiting long
  int         mPen;
  logic       mFlush;
  logic [CNT_W-1:0] mCnt [2];

  always #5 clk = ~clk;

  thread_switch_ctl #(.CNT_W(CNT_W), .SWITCH_LAT(3)) u_thread_switch_ctl (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missLong(missLong),
    .retValid(retValid), .retLong(retLong), .fgThread(fgThread),
    .issueEn(issueEn), .flushReq(flushReq), .allStalled(allStalled),
    .swCnt0(swCnt0), .swCnt1(swCnt1)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mFg = 1'b0; mSt[0] = 0; mSt[1] = 0; mPen = 0; mFlush = 1'b0;
    mCnt[0] = '0; mCnt[1] = '0;
  endtask

  // advance the reference by one cycle using the inputs now applied
  task automatic modelStep();
    logic hit [2];
    logic mIssue, acc, sw, bgRdy;
    int   bg;
    for (int i = 0; i < 2; i++)
      hit[i] = retValid[i] && (mSt[i] != 0) && (retLong[i] == (mSt[i] == 2));
    bg     = mFg ? 0 : 1;
    mIssue = (mPen == 0) && (mSt[mFg] == 0);
    bgRdy  = (mSt[bg] == 0) || hit[bg];
    acc    = mIssue && missValid;
    sw     = (mPen == 0) && (acc ? (missLong || bgRdy) : ((mSt[mFg] != 0) && bgRdy));
    for (int i = 0; i < 2; i++) begin
      if (acc && (i == int'(mFg))) mSt[i] = missLong ? 2 : 1;
      else if (hit[i])             mSt[i] = 0;
    end
    mFlush = sw;
    if (sw) begin
      mCnt[mFg] = mCnt[mFg] + 1'b1;
      mFg  = ~mFg;
      mPen = 2;
    end else if (mPen > 0) begin
      mPen--;
    end
  endtask

  task automatic compareModel();
    check("MODEL fgThread",   fgThread,   mFg);
    check("MODEL issueEn",    issueEn,    (mPen == 0) && (mSt[mFg] == 0));
    check("MODEL flushReq",   flushReq,   mFlush);
    check("MODEL allStalled", allStalled, (mSt[0] != 0) && (mSt[1] != 0));
    check("MODEL swCnt0",     swCnt0,     mCnt[0]);
    check("MODEL swCnt1",     swCnt1,     mCnt[1]);
  endtask

  // apply inputs at a falling edge, run one cycle, sample at the next falling edge
  task automatic cyc(logic mv, logic ml, logic [1:0] rv, logic [1:0] rl);
    missValid = mv; missLong = ml; retValid = rv; retLong = rl;
    modelStep();
    @(posedge clk);
    @(negedge clk);
    missValid = 1'b0; missLong = 1'b0; retValid = '0; retLong = '0;
    compareModel();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 fgThread", fgThread, 0);
    check("R1 issueEn", issueEn, 1);
    check("R1 flushReq", flushReq, 0);
    check("R1 allStalled", allStalled, 0);
    check("R1 swCnt0", swCnt0, 0);
    check("R1 swCnt1", swCnt1, 0);

    // R3: short miss, background running -> switch
    cyc(1, 0, 2'b00, 2'b00);
    check("R3 fgThread", fgThread, 1);
    check("R5 flush in t+1", flushReq, 1);
    check("R5 no issue t+1", issueEn, 0);
    // R6: miss offered during penalty is ignored
    cyc(1, 1, 2'b00, 2'b00);
    check("R5 flush gone t+2", flushReq, 0);
    check("R5 no issue t+2", issueEn, 0);
    cyc(0, 0, 2'b00, 2'b00);
    check("R5 issue at t+3", issueEn, 1);
    check("R6 no second flush", flushReq, 0);
    check("R6 fg kept", fgThread, 1);
    check("R11 swCnt0", swCnt0, 1);

    // R4: short miss while background waits -> stall in place
    cyc(1, 0, 2'b00, 2'b00);
    check("R4 fg kept", fgThread, 1);
    check("R4 no flush", flushReq, 0);
    check("R4 stalled", issueEn, 0);
    check("R8 allStalled", allStalled, 1);
    // R7: completion of the wrong class does nothing
    cyc(0, 0, 2'b10, 2'b10);
    check("R7 mismatch ignored", issueEn, 0);
    // R6: miss while stalled is ignored
    cyc(1, 1, 2'b00, 2'b00);
    check("R6 stalled miss ignored", flushReq, 0);
    // R4/R8: foreground completes first -> resumes without switch
    cyc(0, 0, 2'b10, 2'b00);
    check("R4 resume", issueEn, 1);
    check("R8 no switch on fg return", fgThread, 1);
    check("R8 allStalled clear", allStalled, 0);

    // R10: long miss with background waiting still switches
    cyc(1, 1, 2'b00, 2'b00);
    check("R10 flush", flushReq, 1);
    check("R10 fgThread", fgThread, 0);
    check("R10 allStalled", allStalled, 1);
    cyc(0, 0, 2'b00, 2'b00);
    cyc(0, 0, 2'b00, 2'b00);
    check("R8 no issue both waiting", issueEn, 0);
    // R8: background completes first -> selected
    cyc(0, 0, 2'b10, 2'b10);
    check("R8 bg ready switch", fgThread, 1);
    check("R8 flush", flushReq, 1);
    cyc(0, 0, 2'b00, 2'b00);
    cyc(0, 0, 2'b00, 2'b00);
    check("R8 new fg issues", issueEn, 1);
    check("R11 swCnt0 two", swCnt0, 2);
    check("R11 swCnt1 one", swCnt1, 1);

    // R9: both waiting, both complete together -> background wins
    cyc(1, 0, 2'b00, 2'b00);
    check("R9 setup stalled", allStalled, 1);
    cyc(0, 0, 2'b11, 2'b00);
    check("R9 tie to background", fgThread, 0);
    check("R9 flush", flushReq, 1);
    cyc(0, 0, 2'b00, 2'b00);
    cyc(0, 0, 2'b00, 2'b00);
    check("R9 issue", issueEn, 1);
    check("R11 swCnt1 two", swCnt1, 2);

    // R2..R11: pseudo-random sweep against the reference
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      cyc(lfsr[0] & lfsr[5], lfsr[1], {lfsr[2] & lfsr[7], lfsr[3] & lfsr[9]},
          {lfsr[4], lfsr[11]});
      for (int k = 0; k < 5; k++)
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule